// File: doc/BRIEF.md
# I2S Audio Transmit Channel

This block takes audio samples from a small first-in first-out store and sends them out on a three-wire serial audio link: one data line, a bit clock and a word-select line. Samples are 8, 16 or 32 bits wide and are sent most significant bit first. Word select is low for the left slot and high for the right slot. Each sample starts one bit clock after the word-select edge that opens its slot. In stereo mode each stored word fills one slot. In mono mode each stored word is sent in both slots of a frame.

As master, the channel makes its own bit clock by toggling it on each pulse of a bit-rate strobe, and it sets the slot length in bit clocks. As slave, it follows a bit clock and word select driven from outside, both synchronous to the system clock. A write port fills the store. A level threshold raises an interrupt request and a DMA request, each with its own enable. Per-channel controls are:
- a channel reset, which empties the store and restarts framing;
- stop, which freezes the channel;
- mute, which sends zeros while framing carries on.

An empty store at a slot start sends zeros and sets a sticky underflow flag.

Top module: `i2s_tx_channel`

## Requirements
- R1: The store holds 8 words of 32 bits. `fifoLevel` reports the count and `fifoFull` is high at 8. A write while full is dropped and leaves the count unchanged.
- R2: In master mode, `sckOut` toggles on every `bitStrobe` pulse. The falling edge is the shift point. `wsOut` toggles every `halfM1`+1 shift points, and the first shift point after reset drives it low (left slot).
- R3: The data line changes at each shift point. The sample occupies the low bits of the word, and the size code selects its width: 0 is 8 bits, 1 is 16 bits, 2 is 32 bits. The MSB appears at the first shift point after a word-select edge, and the following bits come one per shift point. Slot positions beyond the sample width carry 0. A slot shorter than the sample sends only its top bits.
- R4: In stereo mode, one word is taken at the start of every slot, and the first word after reset goes to the left slot.
- R5: In mono mode, one word is taken at the start of each left slot and sent in that slot and in the right slot after it.
- R6: In slave mode, a shift point is a high-to-low step of `sckIn`. A new slot starts at a shift point where `wsIn` differs from the current slot, and the current slot takes the value of `wsIn`. `sckOut` and `wsOut` stay low.
- R7: Mute forces the data line to 0. Clocks, framing and word consumption carry on.
- R8: While `stopEn` is high, no shift point occurs. Bit clock, word select, data and the store level all hold.
- R9: `chReset` empties the store, clears the underflow flag and the data line, and restarts framing with word select high.
- R10: A slot that starts with the store empty sends zeros and sets `underflow`, which stays set until `chReset`.
- R11: `irqReq` is `irqEn` AND (level <= `levelThresh`). `dmaReq` is `dmaEn` AND the same comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| chReset | input | 1 | Channel reset: empty store, restart framing |
| masterMode | input | 1 | 1 = generate clocks, 0 = follow external clocks |
| monoMode | input | 1 | 1 = one word per frame sent in both slots |
| stopEn | input | 1 | Freeze the channel |
| muteEn | input | 1 | Send zeros, keep framing |
| wordSize | input | 2 | Sample width code: 0=8, 1=16, 2=32 bits |
| halfM1 | input | 6 | Master slot length in bit clocks minus one |
| bitStrobe | input | 1 | Master bit-clock toggle strobe |
| sckIn | input | 1 | Slave bit clock (synchronous to clk) |
| wsIn | input | 1 | Slave word select |
| wrEn | input | 1 | Write a word into the store |
| wrData | input | 32 | Word to write |
| levelThresh | input | 4 | Request threshold on store level |
| irqEn | input | 1 | Interrupt request enable |
| dmaEn | input | 1 | DMA request enable |
| sckOut | output | 1 | Master bit clock |
| wsOut | output | 1 | Master word select |
| sdOut | output | 1 | Serial data |
| fifoLevel | output | 4 | Words held in the store |
| fifoFull | output | 1 | Store full |
| underflow | output | 1 | Sticky underflow flag |
| irqReq | output | 1 | Interrupt request |
| dmaReq | output | 1 | DMA request |

## Verification
The assertions assume four things about the inputs:
- `sckIn` and `wsIn` are synchronous to `clk`.
- Each `sckIn` level lasts at least one clock.
- `wsIn` changes only together with a falling `sckIn`.
- Mode, size and slot-length inputs change only while the channel is held in channel reset or stopped.

The stimulus writes configuration and performs a channel reset before every run. It drives each slave bit clock as one high clock followed by one low clock, and changes `wsIn` on the same clock as the falling step. It pulses `bitStrobe` only in master runs.

// File: rtl/i2stx_pkg.sv
package i2stx_pkg;
  localparam int POS_W = 6;

  typedef struct packed {
    logic             shift;
    logic             load;
    logic [POS_W-1:0] pos;
  } txStrobe_t;
endpackage

// File: rtl/i2stx_ctrl.sv
module i2stx_ctrl
  import i2stx_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             chReset,
  input  logic             masterMode,
  input  logic             monoMode,
  input  logic             stopEn,
  input  logic [POS_W-1:0] halfM1,
  input  logic             bitStrobe,
  input  logic             sckIn,
  input  logic             wsIn,
  output txStrobe_t        ctl,
  output logic             sckOut,
  output logic             wsOut
);
  logic             sckReg;
  logic             sckPrev;
  logic             wsCur;
  logic [POS_W-1:0] pos;
  logic             tick;
  logic             newHalf;
  logic             nextWs;

  assign tick    = !stopEn && (masterMode ? (bitStrobe && sckReg) : (sckPrev && !sckIn));
  assign newHalf = masterMode ? (pos >= halfM1) : (wsIn != wsCur);
  assign nextWs  = masterMode ? ~wsCur : wsIn;

  always_ff @(posedge clk) begin
    if (!rstN || chReset) begin
      sckReg  <= 1'b0;
      sckPrev <= 1'b0;
      wsCur   <= 1'b1;
      pos     <= '1;
    end else begin
      sckPrev <= sckIn;
      if (!masterMode)
        sckReg <= 1'b0;
      else if (bitStrobe && !stopEn)
        sckReg <= ~sckReg;
      if (tick) begin
        if (newHalf) begin
          wsCur <= nextWs;
          pos   <= '0;
        end else if (pos != '1) begin
          pos <= pos + 1'b1;
        end
      end
    end
  end

  assign ctl.shift = tick;
  assign ctl.load  = tick && newHalf && (!monoMode || !nextWs);
  assign ctl.pos   = pos;
  assign sckOut    = masterMode && sckReg;
  assign wsOut     = masterMode && wsCur;

  p_stop_freeze_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stopEn && !chReset) |=> ($stable(wsCur) && $stable(pos)));
  p_ws_only_on_tick_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.shift && !chReset) |=> $stable(wsCur));
  p_slave_follow_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.shift && !masterMode && !chReset) |=> (wsCur == $past(wsIn)));
endmodule

// File: rtl/i2stx_datapath.sv
module i2stx_datapath
  import i2stx_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1),
  localparam int IW = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chReset,
  input  logic              muteEn,
  input  logic [1:0]        wordSize,
  input  txStrobe_t         ctl,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic [LW-1:0]     levelThresh,
  input  logic              irqEn,
  input  logic              dmaEn,
  output logic              sdOut,
  output logic [LW-1:0]     fifoLevel,
  output logic              fifoFull,
  output logic              underflow,
  output logic              irqReq,
  output logic              dmaReq
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wrPtr, rdPtr;
  logic [LW-1:0]     count;
  logic [DATA_W-1:0] curWord;
  logic              empty, push, pop;
  logic [POS_W:0]    wordBits, posExt, idx;
  logic              bitVal;

  assign empty = (count == '0);
  assign push  = wrEn && !fifoFull;
  assign pop   = ctl.load && !empty;

  always_comb begin
    case (wordSize)
      2'd0:    wordBits = (POS_W+1)'(8);
      2'd1:    wordBits = (POS_W+1)'(16);
      default: wordBits = (POS_W+1)'(32);
    endcase
    posExt = {1'b0, ctl.pos};
    idx    = wordBits - (POS_W+1)'(1) - posExt;
    bitVal = (posExt < wordBits) ? curWord[idx[IW-1:0]] : 1'b0;
  end

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || chReset) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      count     <= '0;
      curWord   <= '0;
      sdOut     <= 1'b0;
      underflow <= 1'b0;
    end else begin
      if (push) wrPtr <= (wrPtr == AW'(DEPTH-1)) ? '0 : wrPtr + 1'b1;
      if (pop)  rdPtr <= (rdPtr == AW'(DEPTH-1)) ? '0 : rdPtr + 1'b1;
      count <= count + LW'(push) - LW'(pop);
      if (ctl.shift) sdOut <= muteEn ? 1'b0 : bitVal;
      if (ctl.load) begin
        curWord <= empty ? '0 : mem[rdPtr];
        if (empty) underflow <= 1'b1;
      end
    end
  end

  assign fifoLevel = count;
  assign fifoFull  = (count == LW'(DEPTH));
  assign irqReq    = irqEn && (count <= levelThresh);
  assign dmaReq    = dmaEn && (count <= levelThresh);

  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rstN)
    count <= LW'(DEPTH));
  p_full_drop_r1: assert property (@(posedge clk) disable iff (!rstN)
    (fifoFull && wrEn && !ctl.load && !chReset) |=> (count == $past(count)));
  p_mute_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (muteEn && ctl.shift && !chReset) |=> !sdOut);
  p_underflow_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    (underflow && !chReset) |=> underflow);
  p_underflow_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && empty && !chReset) |=> (curWord == '0 && underflow));
  p_reset_empty_r9: assert property (@(posedge clk) disable iff (!rstN)
    chReset |=> (count == '0 && !underflow && !sdOut));
endmodule

// File: rtl/i2s_tx_channel.sv
module i2s_tx_channel
  import i2stx_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chReset,
  input  logic              masterMode,
  input  logic              monoMode,
  input  logic              stopEn,
  input  logic              muteEn,
  input  logic [1:0]        wordSize,
  input  logic [POS_W-1:0]  halfM1,
  input  logic              bitStrobe,
  input  logic              sckIn,
  input  logic              wsIn,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic [LW-1:0]     levelThresh,
  input  logic              irqEn,
  input  logic              dmaEn,
  output logic              sckOut,
  output logic              wsOut,
  output logic              sdOut,
  output logic [LW-1:0]     fifoLevel,
  output logic              fifoFull,
  output logic              underflow,
  output logic              irqReq,
  output logic              dmaReq
);
  txStrobe_t ctl;

  i2stx_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .chReset(chReset), .masterMode(masterMode),
    .monoMode(monoMode), .stopEn(stopEn), .halfM1(halfM1), .bitStrobe(bitStrobe),
    .sckIn(sckIn), .wsIn(wsIn), .ctl(ctl), .sckOut(sckOut), .wsOut(wsOut)
  );

  i2stx_datapath #(.DEPTH(DEPTH), .DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .chReset(chReset), .muteEn(muteEn),
    .wordSize(wordSize), .ctl(ctl), .wrEn(wrEn), .wrData(wrData),
    .levelThresh(levelThresh), .irqEn(irqEn), .dmaEn(dmaEn), .sdOut(sdOut),
    .fifoLevel(fifoLevel), .fifoFull(fifoFull), .underflow(underflow),
    .irqReq(irqReq), .dmaReq(dmaReq)
  );
endmodule

// File: tb/sim_i2s_tx_channel.sv
module sim_i2s_tx_channel;
  logic clk = 1'b0;
  logic rstN = 1'b0, chReset = 1'b0, masterMode = 1'b1, monoMode = 1'b0;
  logic stopEn = 1'b0, muteEn = 1'b0, bitStrobe = 1'b0, sckIn = 1'b0, wsIn = 1'b1;
  logic wrEn = 1'b0, irqEn = 1'b0, dmaEn = 1'b0;
  logic [1:0] wordSize = 2'd0;
  logic [5:0] halfM1 = 6'd7;
  logic [31:0] wrData = '0;
  logic [3:0] levelThresh = 4'd0;
  logic sckOut, wsOut, sdOut, fifoFull, underflow, irqReq, dmaReq;
  logic [3:0] fifoLevel;

  always #4 clk = ~clk;

  i2s_tx_channel u0 (.*);

  int nChk = 0, nBad = 0, cyc = 0;
  bit done = 0;
  int cfgWb, cfgH, cfgN;
  bit cfgMono, cfgMute, cfgSlave;
  logic [31:0] samp [10];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      nBad++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("  test done: total=%0d bad=%0d", nChk, nBad);
      $finish;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic expSd(int t);
    int slot, hh, pp, idx;
    slot = t - 2;
    if (slot < 0) return 1'b0;
    hh = slot / cfgH;
    pp = slot % cfgH;
    idx = cfgMono ? hh / 2 : hh;
    if (idx >= cfgN || cfgMute || pp >= cfgWb) return 1'b0;
    return samp[idx][cfgWb - 1 - pp];
  endfunction

  function automatic logic expWs(int t);
    return 1'((((t - 1) / cfgH) % 2));
  endfunction

  task automatic pushWord(logic [31:0] w);
    @(negedge clk); wrEn = 1'b1; wrData = w;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic strobe();
    @(negedge clk); bitStrobe = 1'b1;
    @(negedge clk); bitStrobe = 1'b0;
  endtask

  task automatic pulseReset();
    @(negedge clk); chReset = 1'b1;
    @(negedge clk); chReset = 1'b0;
  endtask

  task automatic doTick(int t);
    string tag;
    tag = cfgMute ? "R7" : cfgSlave ? "R6" : cfgMono ? "R5" : "R3";
    if (cfgSlave) begin
      @(negedge clk); sckIn = 1'b1;
      @(negedge clk); sckIn = 1'b0; wsIn = expWs(t);
      @(negedge clk);
      chk("R6 clocks low", {sckOut, wsOut}, 0);
    end else begin
      strobe();
      chk("R2 sck high", sckOut, 1);
      strobe();
      chk("R2 ws", wsOut, expWs(t));
    end
    chk(tag, sdOut, expSd(t));
  endtask

  task automatic setup(int code, int h, bit mono, int n, bit slave, bit mute);
    cfgWb = 8 << code; cfgH = h; cfgN = n;
    cfgMono = mono; cfgSlave = slave; cfgMute = mute;
    for (int i = 0; i < 10; i++)
      samp[i] = (32'h9E3779B9 * (i + 3 + code * 5 + h)) ^ (32'h5A5A0000 >> i);
    @(negedge clk);
    wordSize = 2'(code); halfM1 = 6'(h - 1); monoMode = mono;
    masterMode = !slave; muteEn = mute; sckIn = 1'b0; wsIn = 1'b1;
    pulseReset();
  endtask

  task automatic runCfg(int code, int h, bit mono, int n, int nPush, bit slave, bit mute);
    int halves, last;
    setup(code, h, mono, n, slave, mute);
    for (int i = 0; i < nPush; i++) pushWord(samp[i]);
    halves = mono ? 2 * n : n;
    last = (halves + 1) * h + 1;
    for (int t = 1; t <= last; t++) begin
      doTick(t);
      if (t == halves * h) chk("R10 no underflow yet", underflow, 0);
    end
    chk("R10 underflow set", underflow, 1);
    chk("R4 all consumed", fifoLevel, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R9 reset ws", wsOut, 1);
    chk("R9 reset sck/sd", {sckOut, sdOut}, 0);
    chk("R9 reset level", fifoLevel, 0);
    chk("R10 reset flag", underflow, 0);

    // R3 R4 R5: sweep size, mono and slot length (exact and padded)
    for (int code = 0; code < 3; code++)
      for (int m = 0; m < 2; m++)
        for (int pad = 0; pad < 2; pad++)
          runCfg(code, (8 << code) + pad * 3, m[0], 3, 3, 1'b0, 1'b0);
    // R3: slot shorter than sample (truncation)
    runCfg(1, 10, 1'b0, 2, 2, 1'b0, 1'b0);
    // R6: slave mode
    runCfg(1, 16, 1'b0, 3, 3, 1'b1, 1'b0);
    runCfg(0, 9, 1'b1, 2, 2, 1'b1, 1'b0);
    // R7: mute keeps framing and consumption
    runCfg(1, 16, 1'b0, 2, 2, 1'b0, 1'b1);

    // R1: overflow writes dropped, stream shows only first 8 words
    setup(0, 8, 1'b0, 8, 1'b0, 1'b0);
    for (int i = 0; i < 10; i++) pushWord(samp[i]);
    chk("R1 level full", fifoLevel, 8);
    chk("R1 full flag", fifoFull, 1);
    for (int t = 1; t <= 9 * 8 + 1; t++) doTick(t);
    chk("R1 extra words dropped", underflow, 1);

    // R8: stop freezes everything
    setup(0, 8, 1'b0, 3, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) pushWord(samp[i]);
    for (int t = 1; t <= 5; t++) doTick(t);
    begin
      logic [6:0] snap;
      @(negedge clk); stopEn = 1'b1;
      snap = {sckOut, wsOut, sdOut, fifoLevel};
      for (int k = 0; k < 5; k++) begin
        strobe();
        chk("R8 frozen", {sckOut, wsOut, sdOut, fifoLevel}, snap);
      end
      @(negedge clk); stopEn = 1'b0;
    end
    for (int t = 6; t <= 4 * 8 + 1; t++) doTick(t);
    chk("R10 after stop", underflow, 1);

    // R9: channel reset mid-stream
    pushWord(32'hFFFF_FFFF); pushWord(32'hFFFF_FFFF);
    doTick(1);
    pulseReset();
    @(negedge clk);
    chk("R9 level cleared", fifoLevel, 0);
    chk("R9 underflow cleared", underflow, 0);
    chk("R9 ws high", wsOut, 1);
    chk("R9 sd/sck low", {sdOut, sckOut}, 0);

    // R11: threshold requests
    levelThresh = 4'd2; irqEn = 1'b1; dmaEn = 1'b1;
    @(negedge clk);
    chk("R11 irq empty", irqReq, 1);
    for (int k = 1; k <= 5; k++) begin
      pushWord(32'h1);
      chk("R11 irq", irqReq, (k <= 2));
      chk("R11 dma", dmaReq, (k <= 2));
    end
    pulseReset();
    dmaEn = 1'b0;
    @(negedge clk);
    chk("R11 dma disabled", dmaReq, 0);
    chk("R11 irq enabled", irqReq, 1);
    irqEn = 1'b0;
    @(negedge clk);
    chk("R11 irq disabled", irqReq, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end
endmodule